// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device side of one parallel-ATA disk channel, seen from the host register port. The host reads and writes byte registers at eight offsets: sector count, the three address bytes and device/head. It writes commands and reads status and error through the same offsets, and it reads 16-bit words from a data port. A command sequencer behind the register file executes three commands. IDENTIFY offers a computed 256-word identification block over the data port. EXECUTE DIAGNOSTIC reports a passing code and forces unit 0 in device/head. FLUSH CACHE holds the device busy until a storage back-end acknowledges. Any other opcode is aborted.

Command completion raises an interrupt line, and a host read of the status register drops it. A mask input stands in for the device-control interrupt-disable bit, and a parameter can remove that mask. The back-end sees a request level that is held until it returns a one-cycle done pulse. Register reads are combinational on the same cycle as the read strobe. Their side effects (clearing the interrupt, advancing the word pointer) take place at the clock edge that ends the strobe.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: Offsets 2, 3, 4, 5 and 6 (sector count, address low, mid, high, device/head) store the written byte and return it on read. Offset 1 returns the error register on read, and a write to it changes no readable register. Every non-data read returns zero in bits 15:8.
- R2: After reset, status (offset 7) reads 0x40, error reads 0x00, all byte registers read 0x00, the interrupt is low and the back-end request is low.
- R3: A host read of status at offset 7 deasserts the interrupt at the clock edge that ends the read, unless a completion occurs on that same edge.
- R4: After IDENTIFY (0xEC), status reads 0x48 (DRDY bit 6 and DRQ bit 3) while words remain. Each read at offset 0 consumes one word. After the 256th read, status reads 0x40.
- R5: Identify word 0 is 0x0040 and word 49 is 0x0200. Words 60 and 61 are the low and high halves of the CAPACITY parameter. Word 82 is 0x0020. Word 85 is 0x0020 when WCACHE_EN is 1, because bit 5 is the write-cache-enabled flag. Every other word is 0. A data read with DRQ clear returns 0 and consumes nothing.
- R6: IDENTIFY, EXECUTE DIAGNOSTIC and an aborted opcode raise the interrupt at the edge that accepts the command. FLUSH CACHE raises it at the edge that takes the done pulse.
- R7: EXECUTE DIAGNOSTIC (0x90) clears device/head bit 4 (unit select) and keeps the other bits. It leaves error at 0x01 and status at 0x40.
- R8: While FLUSH CACHE (0xE7) is outstanding, status reads 0xC0 (BSY bit 7 and DRDY) and the back-end request is high. On the done pulse, status returns to 0x40 and the request drops.
- R9: Any opcode other than 0xEC, 0x90 and 0xE7 leaves status 0x41 (ERR bit 0) and error 0x04 (abort bit 2). An accepted known command clears ERR.
- R10: A command written while BSY is set is ignored: status, error, device/head and the back-end request are unchanged.
- R11: While the interrupt-disable input is high, no completion raises the interrupt, but status and error still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Task-file offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 16 | Read data (16 bits at offset 0, byte zero-extended elsewhere) |
| host_irq | output | 1 | Interrupt request to the host |
| irq_disable | input | 1 | Interrupt-disable level from the device-control register |
| be_flush_req | output | 1 | Flush request to the storage back-end |
| be_flush_done | input | 1 | One-cycle flush completion from the back-end |

## Verification
The embedded assertions check several properties on every cycle. A status read drops the interrupt. The mask keeps the interrupt quiet. An outstanding flush stays busy until the done pulse. The last identify word drops DRQ. An abort leaves exactly status 0x41 and error 0x04. Diagnostic leaves unit 0 selected. Only the bench scenarios can show the full content of the identify block, the readback of each register offset, and the fact that a command written during a flush leaves no trace after it completes. The bench sweeps all 256 opcodes, each followed by a status read, and compares all 256 identify words against values computed from the CAPACITY and write-cache settings.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

   localparam int unsigned TF_ADDR_W = 3;

   localparam logic [TF_ADDR_W-1:0] OFS_DATA    = 3'd0;
   localparam logic [TF_ADDR_W-1:0] OFS_ERRFEAT = 3'd1;
   localparam logic [TF_ADDR_W-1:0] OFS_NSECT   = 3'd2;
   localparam logic [TF_ADDR_W-1:0] OFS_DEVHEAD = 3'd6;
   localparam logic [TF_ADDR_W-1:0] OFS_CMDSTAT = 3'd7;

   localparam int unsigned STB_BSY  = 7;
   localparam int unsigned STB_DRDY = 6;
   localparam int unsigned STB_DF   = 5;
   localparam int unsigned STB_DRQ  = 3;
   localparam int unsigned STB_ERR  = 0;
   localparam int unsigned ERB_ABRT = 2;
   localparam int unsigned DHB_UNIT = 4;

   localparam logic [7:0] OPC_IDENTIFY = 8'hEC;
   localparam logic [7:0] OPC_DIAG     = 8'h90;
   localparam logic [7:0] OPC_FLUSH    = 8'hE7;

   localparam logic [7:0] DIAG_PASS    = 8'h01;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_PIOIN = 2'd1,
      SQ_FLUSH = 2'd2
   } seq_state_e;

   function automatic logic [7:0] build_status(input logic bsy, input logic drq,
                                               input logic err);
      logic [7:0] s;
      s           = 8'h00;
      s[STB_BSY]  = bsy;
      s[STB_DRDY] = 1'b1;
      s[STB_DF]   = 1'b0;
      s[STB_DRQ]  = drq;
      s[STB_ERR]  = err;
      return s;
   endfunction

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
   import ata_tf_pkg::*;
#(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned FIRST_OFS  = 2,
   parameter int unsigned NUM_REGS   = 5,
   parameter int unsigned UNIT_SLOT  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [TF_ADDR_W-1:0]        wr_addr,
   input  logic [REG_W-1:0]            wr_data,
   input  logic                        unit_clr,
   output logic [NUM_REGS*REG_W-1:0]   regs_flat
);

   localparam int unsigned LAST_OFS = FIRST_OFS + NUM_REGS - 1;

   if (LAST_OFS >= (1 << TF_ADDR_W)) begin : g_bad_span
      $error("register span exceeds the offset space");
   end
   if (UNIT_SLOT >= NUM_REGS) begin : g_bad_slot
      $error("unit-select slot outside the register file");
   end

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      localparam logic [TF_ADDR_W-1:0] MY_OFS = TF_ADDR_W'(FIRST_OFS + k);
      logic [REG_W-1:0] val_q;

      if (k == UNIT_SLOT) begin : g_unit
         always_ff @(posedge clk) begin
            if (!rst_n)
               val_q <= '0;
            else if (wr_en && (wr_addr == MY_OFS))
               val_q <= wr_data;
            else if (unit_clr)
               val_q[DHB_UNIT] <= 1'b0;
         end

         AST_DIAG_UNIT0: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_clr && !wr_en) |=> (val_q[DHB_UNIT] == 1'b0)); // R7
         AST_DIAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (unit_clr && !wr_en) |=> (val_q[REG_W-1:DHB_UNIT+1] == $past(val_q[REG_W-1:DHB_UNIT+1]))); // R7
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               val_q <= '0;
            else if (wr_en && (wr_addr == MY_OFS))
               val_q <= wr_data;
         end
      end

      assign regs_flat[k*REG_W +: REG_W] = val_q;
   end

endmodule

// File: rtl/ata_tf_ident.sv
module ata_tf_ident #(
   parameter int unsigned WORDS     = 256,
   parameter int unsigned WORD_W    = 16,
   parameter logic [31:0] CAPACITY  = 32'h0012_3456,
   parameter bit          WCACHE_EN = 1'b1,
   localparam int unsigned IDX_W    = $clog2(WORDS)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [WORD_W-1:0] word
);

   localparam int unsigned W_CONFIG = 0;
   localparam int unsigned W_CAPS   = 49;
   localparam int unsigned W_CAP_LO = 60;
   localparam int unsigned W_CAP_HI = 61;
   localparam int unsigned W_FEAT_S = 82;
   localparam int unsigned W_FEAT_E = 85;
   localparam int unsigned WC_BIT   = 5;

   if (WORDS <= W_FEAT_E) begin : g_bad_words
      $error("identify block too short for the feature words");
   end
   if (WORD_W != 16) begin : g_bad_width
      $error("identify words must be 16 bits");
   end

   logic [WORD_W-1:0] wc_word;

   if (WCACHE_EN) begin : g_wc_on
      assign wc_word = WORD_W'(1) << WC_BIT;
   end else begin : g_wc_off
      assign wc_word = '0;
   end

   always_comb begin
      unique case (int'(idx))
         W_CONFIG: word = 16'h0040;
         W_CAPS:   word = 16'h0200;
         W_CAP_LO: word = CAPACITY[15:0];
         W_CAP_HI: word = CAPACITY[31:16];
         W_FEAT_S: word = WORD_W'(1) << WC_BIT;
         W_FEAT_E: word = wc_word;
         default:  word = '0;
      endcase
   end

endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
   import ata_tf_pkg::*;
#(
   parameter int unsigned WORDS    = 256,
   parameter bit          HAS_NIEN = 1'b1,
   localparam int unsigned IDX_W   = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [7:0]        cmd_op,
   input  logic              stat_rd,
   input  logic              data_rd,
   input  logic              be_done,
   input  logic              nien,
   output logic [7:0]        status,
   output logic [7:0]        error,
   output logic              irq,
   output logic              drq,
   output logic [IDX_W-1:0]  word_idx,
   output logic              be_req,
   output logic              unit_clr
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   if (WORDS < 2 || (1 << IDX_W) != WORDS) begin : g_bad_words
      $error("identify word count must be a power of two");
   end

   seq_state_e       state_q;
   logic             err_q;
   logic [7:0]       error_q;
   logic             irq_q;
   logic [IDX_W-1:0] idx_q;
   logic             mask;
   logic             busy;
   logic             accept;
   logic             known_op;
   logic             flush_end;

   if (HAS_NIEN) begin : g_mask
      assign mask = nien;
   end else begin : g_nomask
      assign mask = 1'b0;
   end

   assign busy      = (state_q == SQ_FLUSH);
   assign accept    = cmd_wr && !busy;
   assign flush_end = busy && be_done;
   assign known_op  = (cmd_op == OPC_IDENTIFY) || (cmd_op == OPC_DIAG) ||
                      (cmd_op == OPC_FLUSH);
   assign unit_clr  = accept && (cmd_op == OPC_DIAG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         err_q   <= 1'b0;
         error_q <= 8'h00;
         irq_q   <= 1'b0;
         idx_q   <= '0;
      end else if (accept) begin
         idx_q <= '0;
         irq_q <= 1'b0;
         unique case (cmd_op)
            OPC_IDENTIFY: begin
               state_q <= SQ_PIOIN;
               err_q   <= 1'b0;
               error_q <= 8'h00;
               irq_q   <= !mask;
            end
            OPC_DIAG: begin
               state_q <= SQ_IDLE;
               err_q   <= 1'b0;
               error_q <= DIAG_PASS;
               irq_q   <= !mask;
            end
            OPC_FLUSH: begin
               state_q <= SQ_FLUSH;
               err_q   <= 1'b0;
               error_q <= 8'h00;
            end
            default: begin
               state_q <= SQ_IDLE;
               err_q   <= 1'b1;
               error_q <= 8'(1) << ERB_ABRT;
               irq_q   <= !mask;
            end
         endcase
      end else begin
         if (state_q == SQ_PIOIN && data_rd) begin
            if (idx_q == LAST_IDX) begin
               state_q <= SQ_IDLE;
               idx_q   <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
         if (stat_rd)
            irq_q <= 1'b0;
         if (flush_end) begin
            state_q <= SQ_IDLE;
            if (!mask)
               irq_q <= 1'b1;
         end
      end
   end

   assign drq      = (state_q == SQ_PIOIN);
   assign status   = build_status(busy, drq, err_q);
   assign error    = error_q;
   assign irq      = irq_q;
   assign word_idx = idx_q;
   assign be_req   = busy;

   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !cmd_wr && !be_done) |=> !irq); // R3
   AST_PIO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (drq && data_rd && !cmd_wr && (word_idx == LAST_IDX)) |=> (status == 8'h40)); // R4
   AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req && !be_done) |=> (be_req && status == 8'hC0 && $stable(error))); // R10
   AST_FLUSH_END: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req && be_done) |=> (!be_req && status[STB_BSY] == 1'b0 && status[STB_DRDY])); // R8
   AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !be_req && !known_op) |=> (status == 8'h41 && error == 8'h04)); // R9
   AST_NIEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (nien && HAS_NIEN && !irq) |=> !irq); // R11
   AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[STB_BSY] && status[STB_DRQ])); // R8

endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
   import ata_tf_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned REG_W     = 8,
   parameter int unsigned ID_WORDS  = 256,
   parameter logic [31:0] CAPACITY  = 32'h0012_3456,
   parameter bit          WCACHE_EN = 1'b1,
   parameter bit          HAS_NIEN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [2:0]        host_addr,
   input  logic [7:0]        host_wdata,
   output logic [15:0]       host_rdata,
   output logic              host_irq,
   input  logic              irq_disable,
   output logic              be_flush_req,
   input  logic              be_flush_done
);

   localparam int unsigned IDX_W     = $clog2(ID_WORDS);
   localparam int unsigned NUM_REGS  = 5;
   localparam int unsigned FIRST_OFS = 2;
   localparam int unsigned UNIT_SLOT = OFS_DEVHEAD - FIRST_OFS;

   if (DATA_W != 16 || REG_W != 8) begin : g_bad_port
      $error("host port widths are fixed at 16 and 8");
   end

   logic                       cmd_wr, stat_rd, data_rd;
   logic [7:0]                 status, error;
   logic                       drq, unit_clr;
   logic [IDX_W-1:0]           word_idx;
   logic [DATA_W-1:0]          id_word;
   logic [NUM_REGS*REG_W-1:0]  regs_flat;

   assign cmd_wr  = host_wr && (host_addr == OFS_CMDSTAT);
   assign stat_rd = host_rd && (host_addr == OFS_CMDSTAT);
   assign data_rd = host_rd && (host_addr == OFS_DATA);

   ata_tf_regs #(
      .REG_W     (REG_W),
      .FIRST_OFS (FIRST_OFS),
      .NUM_REGS  (NUM_REGS),
      .UNIT_SLOT (UNIT_SLOT)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (host_wr),
      .wr_addr   (host_addr),
      .wr_data   (host_wdata),
      .unit_clr  (unit_clr),
      .regs_flat (regs_flat)
   );

   ata_tf_seq #(
      .WORDS    (ID_WORDS),
      .HAS_NIEN (HAS_NIEN)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .cmd_op   (host_wdata),
      .stat_rd  (stat_rd),
      .data_rd  (data_rd),
      .be_done  (be_flush_done),
      .nien     (irq_disable),
      .status   (status),
      .error    (error),
      .irq      (host_irq),
      .drq      (drq),
      .word_idx (word_idx),
      .be_req   (be_flush_req),
      .unit_clr (unit_clr)
   );

   ata_tf_ident #(
      .WORDS     (ID_WORDS),
      .WORD_W    (DATA_W),
      .CAPACITY  (CAPACITY),
      .WCACHE_EN (WCACHE_EN)
   ) ident_i (
      .idx  (word_idx),
      .word (id_word)
   );

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         OFS_DATA:    host_rdata = drq ? id_word : '0;
         OFS_ERRFEAT: host_rdata = DATA_W'(error);
         OFS_CMDSTAT: host_rdata = DATA_W'(status);
         default:     host_rdata = DATA_W'(regs_flat[(int'(host_addr) - FIRST_OFS)*REG_W +: REG_W]);
      endcase
   end

   AST_HIGH_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr != OFS_DATA) |-> (host_rdata[15:8] == 8'h00)); // R1
   AST_DATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == OFS_DATA && !status[STB_DRQ]) |-> (host_rdata == '0)); // R5

endmodule

// File: tb/ata_taskfile_ctrl_tb_top.sv
`timescale 1ns/1ps
module ata_taskfile_ctrl_tb_top;

   localparam logic [31:0] CAP = 32'h0012_3456;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [2:0]  host_addr = 3'd0;
   logic [7:0]  host_wdata = 8'h00;
   logic [15:0] host_rdata;
   logic        host_irq;
   logic        irq_disable = 1'b0;
   logic        be_flush_req;
   logic        be_flush_done = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   ata_taskfile_ctrl #(.CAPACITY(CAP), .WCACHE_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_irq(host_irq), .irq_disable(irq_disable),
      .be_flush_req(be_flush_req), .be_flush_done(be_flush_done)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      be_flush_done = 1'b1;
      @(negedge clk);
      be_flush_done = 1'b0;
   endtask

   function automatic logic [15:0] exp_word(input int i);
      case (i)
         0:  return 16'h0040;
         49: return 16'h0200;
         60: return CAP[15:0];
         61: return CAP[31:16];
         82: return 16'h0020;
         85: return 16'h0020;
         default: return 16'h0000;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      rd(3'd7, d); chk("R2 status", d, 16'h0040);
      rd(3'd1, d); chk("R2 error", d, 16'h0000);
      for (int a = 2; a <= 6; a++) begin
         rd(3'(a), d); chk("R2 reg", d, 16'h0000);
      end
      chk("R2 irq", {15'd0, host_irq}, 16'h0000);
      chk("R2 be_req", {15'd0, be_flush_req}, 16'h0000);

      // R1 register readback sweep
      for (int a = 2; a <= 6; a++) begin
         for (int p = 0; p < 4; p++) begin
            logic [7:0] v;
            v = 8'(8'h5A ^ (a * 37) ^ (p * 8'h63));
            wr(3'(a), v);
            rd(3'(a), d); chk("R1 readback", d, {8'h00, v});
         end
      end
      wr(3'd1, 8'hFF);
      rd(3'd1, d); chk("R1 feature write invisible", d, 16'h0000);
      rd(3'd7, d); chk("R1 status after feature write", d, 16'h0040);

      // R5 data read without DRQ
      rd(3'd0, d); chk("R5 idle data", d, 16'h0000);

      // R4 R5 R6 identify
      wr(3'd7, 8'hEC);
      chk("R6 identify irq", {15'd0, host_irq}, 16'h0001);
      rd(3'd7, d); chk("R4 status pending", d, 16'h0048);
      chk("R3 irq cleared", {15'd0, host_irq}, 16'h0000);
      for (int i = 0; i < 256; i++) begin
         rd(3'd7, d); chk("R4 status per word", d, 16'h0048);
         rd(3'd0, d); chk("R5 identify word", d, exp_word(i));
      end
      rd(3'd7, d); chk("R4 status after last word", d, 16'h0040);
      rd(3'd0, d); chk("R5 data after drain", d, 16'h0000);

      // R7 diagnostic
      wr(3'd6, 8'hF5);
      wr(3'd7, 8'h90);
      chk("R6 diag irq", {15'd0, host_irq}, 16'h0001);
      rd(3'd6, d); chk("R7 unit cleared", d, 16'h00E5);
      rd(3'd1, d); chk("R7 diag code", d, 16'h0001);
      rd(3'd7, d); chk("R7 status", d, 16'h0040);

      // R8 R10 flush with ignored command
      wr(3'd6, 8'h50);
      wr(3'd7, 8'hE7);
      rd(3'd7, d); chk("R8 busy status", d, 16'h00C0);
      chk("R8 be_req", {15'd0, be_flush_req}, 16'h0001);
      chk("R6 no irq before done", {15'd0, host_irq}, 16'h0000);
      wr(3'd7, 8'h90);
      wr(3'd7, 8'hEC);
      wr(3'd7, 8'h33);
      rd(3'd7, d); chk("R10 status unchanged", d, 16'h00C0);
      rd(3'd1, d); chk("R10 error unchanged", d, 16'h0000);
      rd(3'd6, d); chk("R10 devhead unchanged", d, 16'h0050);
      chk("R10 be_req held", {15'd0, be_flush_req}, 16'h0001);
      done_pulse();
      chk("R8 be_req dropped", {15'd0, be_flush_req}, 16'h0000);
      chk("R6 flush irq", {15'd0, host_irq}, 16'h0001);
      rd(3'd7, d); chk("R8 done status", d, 16'h0040);
      chk("R3 irq cleared", {15'd0, host_irq}, 16'h0000);

      // R11 masked interrupt
      irq_disable = 1'b1;
      wr(3'd7, 8'h00);
      chk("R11 irq masked", {15'd0, host_irq}, 16'h0000);
      rd(3'd7, d); chk("R11 status updates", d, 16'h0041);
      rd(3'd1, d); chk("R11 error updates", d, 16'h0004);
      wr(3'd7, 8'hE7);
      done_pulse();
      chk("R11 flush irq masked", {15'd0, host_irq}, 16'h0000);
      rd(3'd7, d); chk("R11 flush status", d, 16'h0040);
      irq_disable = 1'b0;

      // R6 R9 R3 sweep of every opcode
      for (int op = 0; op < 256; op++) begin
         wr(3'd6, 8'h50);
         wr(3'd7, 8'(op));
         if (op == 8'hEC) begin
            chk("R6 sweep irq", {15'd0, host_irq}, 16'h0001);
            rd(3'd7, d); chk("R4 sweep status", d, 16'h0048);
            for (int i = 0; i < 256; i++) rd(3'd0, d);
            rd(3'd7, d); chk("R4 sweep drained", d, 16'h0040);
         end else if (op == 8'h90) begin
            chk("R6 sweep irq", {15'd0, host_irq}, 16'h0001);
            rd(3'd6, d); chk("R7 sweep unit", d, 16'h0040);
            rd(3'd7, d); chk("R9 sweep known clears err", d, 16'h0040);
         end else if (op == 8'hE7) begin
            rd(3'd7, d); chk("R8 sweep busy", d, 16'h00C0);
            done_pulse();
            chk("R6 sweep irq", {15'd0, host_irq}, 16'h0001);
            rd(3'd7, d); chk("R9 sweep known clears err", d, 16'h0040);
         end else begin
            chk("R6 sweep irq", {15'd0, host_irq}, 16'h0001);
            rd(3'd7, d); chk("R9 sweep abort status", d, 16'h0041);
            rd(3'd1, d); chk("R9 sweep abort error", d, 16'h0004);
         end
         chk("R3 sweep irq cleared", {15'd0, host_irq}, 16'h0000);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule